// File: doc/BRIEF.md
# Block Write-Guard with Lock Registers

This block decides, for every address offered by the command sequencer, whether a program or erase may proceed there. The storage array is split into 64 KByte blocks. Two active-low hardware pins take part in the decision. `boot_guard_n` covers only the highest block. `main_guard_n` covers every other block. Beside the pins, each block owns a small lock register with a write-lock bit and a lock-down bit.

The lock registers sit behind a simple register port with a select, a write strobe, write data and combinational read data. The select counts down from the top of the array, so index 0 is the highest block. Software clears or sets write-lock through this port. Setting lock-down freezes the register until the next reset. The single output `permit` is combinational in the offered address. A register write changes `permit` from the following cycle onward.

Top module: `blk_wr_guard`

## Requirements
- R1: After reset, every lock register reads 0x01 (write-lock set, lock-down clear), so `permit` is low for every address.
- R2: When `boot_guard_n` is low, `permit` is low for any address in the top block (address bits [18:16] equal to 7), whatever that block's lock register holds.
- R3: When `main_guard_n` is low, `permit` is low for any address in blocks 0 to 6. `main_guard_n` has no effect on the top block.
- R4: Register select k addresses the lock register of block 7-k. Select 0 is the top block.
- R5: Read data carries write-lock in bit 0 and lock-down in bit 1. Bits 7 to 2 always read zero.
- R6: A write to a register whose lock-down is clear loads bit 0 of the write data into write-lock and bit 1 into lock-down. Bits 7 to 2 of the write data are ignored.
- R7: Once lock-down is set, writes to that register leave both of its bits unchanged.
- R8: `permit` is high only when the pin covering the addressed block is high and that block's write-lock is clear. A register write is seen by `permit` from the cycle after the write strobe.
- R9: A later reset clears every lock-down bit and sets every write-lock bit again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| boot_guard_n | input | 1 | Protects the top block when low |
| main_guard_n | input | 1 | Protects all other blocks when low |
| chk_addr | input | 19 | Byte address of the pending program or erase |
| permit | output | 1 | High when that address may be modified |
| reg_sel | input | 3 | Lock register select (0 = top block) |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |

## Verification
A register write and a permit query for the same block can fall in the same cycle. The query must see the old lock state, and the new state only from the next cycle. The bench provokes this by writing a block's register while `chk_addr` points into that block. It does this both in directed steps and in a long pseudo-random phase where select, address, data and pins change every cycle. A behavioural model updated at each rising edge predicts `permit` and `reg_rdata`, and both are compared at every falling edge. The same comparison covers a write that sets lock-down and a later write in the same cycle that the pins change.

// File: rtl/blk_wr_guard.sv
module blk_wr_guard #(
  parameter int NUM_BLK = 8,
  parameter int BLK_AW  = 16,
  parameter int REG_W   = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  boot_guard_n,
  input  logic                                  main_guard_n,
  input  logic [BLK_AW+$clog2(NUM_BLK)-1:0]     chk_addr,
  output logic                                  permit,
  input  logic [$clog2(NUM_BLK)-1:0]            reg_sel,
  input  logic                                  reg_wr,
  input  logic [REG_W-1:0]                      reg_wdata,
  output logic [REG_W-1:0]                      reg_rdata
);
  localparam int SEL_W  = $clog2(NUM_BLK);
  localparam int ADDR_W = BLK_AW + SEL_W;
  localparam logic [SEL_W-1:0] TOP = SEL_W'(NUM_BLK - 1);

  logic [NUM_BLK-1:0] wl;
  logic [NUM_BLK-1:0] ld;
  logic [SEL_W-1:0]   reg_blk;
  logic [SEL_W-1:0]   q_blk;
  logic               pin_hit;

  assign reg_blk = TOP - reg_sel;
  assign q_blk   = chk_addr[ADDR_W-1 -: SEL_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wl <= '1;
      ld <= '0;
    end else if (reg_wr && !ld[reg_blk]) begin
      wl[reg_blk] <= reg_wdata[0];
      ld[reg_blk] <= reg_wdata[1];
    end
  end

  assign reg_rdata = {{(REG_W-2){1'b0}}, ld[reg_blk], wl[reg_blk]};
  assign pin_hit   = (q_blk == TOP) ? !boot_guard_n : !main_guard_n;
  assign permit    = !pin_hit && !wl[q_blk];

  p_boot_pin_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (q_blk == TOP && !boot_guard_n) |-> !permit);

  p_main_pin_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (q_blk != TOP && !main_guard_n) |-> !permit);

  p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !ld[reg_blk]) |=> (wl[$past(reg_blk)] == $past(reg_wdata[0])));

  p_lock_refuses_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wl[q_blk] |-> !permit);

  for (genvar i = 0; i < NUM_BLK; i++) begin : g_chk
    p_ldown_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ld[i] |=> (ld[i] && $stable(wl[i])));
  end
endmodule

// File: tb/blk_wr_guard_tb.sv
module blk_wr_guard_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_guard_n = 1'b1;
  logic        main_guard_n = 1'b1;
  logic [18:0] chk_addr = '0;
  logic        permit;
  logic [2:0]  reg_sel = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  string phase = "R1";
  bit m_wl [8];
  bit m_ld [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_wr_guard u_dut (
    .clk(clk), .rst_n(rst_n), .boot_guard_n(boot_guard_n), .main_guard_n(main_guard_n),
    .chk_addr(chk_addr), .permit(permit), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // Reference model: register state changes at the rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin m_wl[i] = 1'b1; m_ld[i] = 1'b0; end
    end else if (reg_wr && !m_ld[7 - reg_sel]) begin
      m_wl[7 - reg_sel] = reg_wdata[0];
      m_ld[7 - reg_sel] = reg_wdata[1];
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int rb, qb;
      bit exp_pm, pin;
      logic [7:0] exp_rd;
      string ptag;
      rb = 7 - reg_sel;
      qb = chk_addr[18:16];
      exp_rd = {6'b0, m_ld[rb], m_wl[rb]};
      pin = (qb == 7) ? !boot_guard_n : !main_guard_n;
      exp_pm = !pin && !m_wl[qb];
      ptag = !pin ? "R8" : ((qb == 7) ? "R2" : "R3");
      compared++;
      if (reg_rdata !== exp_rd) begin
        mismatched++;
        $display("FAIL %s R4 R5 R6 R7 rdata sel=%0d: actual=%02h expected=%02h",
                 phase, reg_sel, reg_rdata, exp_rd);
      end
      compared++;
      if (permit !== exp_pm) begin
        mismatched++;
        $display("FAIL %s %s permit blk=%0d: actual=%0b expected=%0b",
                 phase, ptag, qb, permit, exp_pm);
      end
    end
  end

  task automatic step(input logic [2:0] sel, input logic wr, input logic [7:0] wd,
                      input logic [18:0] addr, input logic bg, input logic mg);
    @(negedge clk); #1;
    reg_sel = sel; reg_wr = wr; reg_wdata = wd; chk_addr = addr;
    boot_guard_n = bg; main_guard_n = mg;
  endtask

  task automatic sweep(input logic bg, input logic mg);
    for (int b = 0; b < 8; b++) step(3'(b), 1'b0, 8'h00, {3'(b), 16'h1234}, bg, mg);
  endtask

  task automatic do_reset();
    @(negedge clk); #1; rst_n = 1'b0; reg_wr = 1'b0;
    repeat (2) @(negedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    logic [15:0] lf;
    do_reset();
    phase = "R1"; sweep(1, 1);
    phase = "R6";
    for (int k = 0; k < 8; k++) step(3'(k), 1'b1, 8'h00, 19'h0, 1, 1);
    sweep(1, 1);
    phase = "R2"; sweep(0, 1);
    phase = "R3"; sweep(1, 0); sweep(0, 0);
    phase = "R5"; step(3'd2, 1'b1, 8'hFD, 19'h5_0000, 1, 1); sweep(1, 1);
    phase = "R7";
    step(3'd0, 1'b1, 8'h02, 19'h7_0000, 1, 1);
    step(3'd0, 1'b1, 8'h01, 19'h7_0000, 1, 1);
    step(3'd0, 1'b1, 8'h03, 19'h7_FFFF, 1, 1);
    step(3'd5, 1'b1, 8'h03, 19'h2_0000, 1, 1);
    step(3'd5, 1'b1, 8'h00, 19'h2_0000, 1, 1);
    sweep(1, 1);
    phase = "R8";
    step(3'd3, 1'b1, 8'h01, 19'h4_0010, 1, 1);
    step(3'd3, 1'b1, 8'h00, 19'h4_0010, 1, 1);
    step(3'd3, 1'b0, 8'h00, 19'h4_0010, 1, 1);
    phase = "R9"; do_reset(); sweep(1, 1);
    phase = "R8";
    lf = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[2:0], lf[3] & lf[9], {lf[15:10], lf[5:4]}, {lf[8:6], lf[15:0] ^ 16'h3C5A},
           lf[11] | lf[12], lf[13] | lf[14]);
    end
    step(3'd0, 1'b0, 8'h00, 19'h0, 1, 1);
    @(negedge clk); #1;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL R8 watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule